// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a general-purpose up-counter with a compare register. A programmable prescaler, fed either by the system clock or by the system clock divided down by a fixed power of two, sets the tick rate. On each tick the count advances by one. When a tick brings the count to the programmed reference value, a sticky match flag is set. The counter can optionally return to zero on the tick after a match. If the match interrupt is enabled, the level interrupt output follows the flag.

Software drives the block through a byte-addressed register port. A write is a single-cycle strobe with an offset and a data word. Read data is a combinational function of the offset. Writing the mode or reference register restarts the count from zero and clears the prescaler. Writing the count register loads a new count and leaves the prescaler alone. The match flag is cleared by writing a one to its position.

Top module: `refcmp_timer`

## Requirements
- R1: After reset the mode, reference, capture, count and event registers all read zero, and `irq` is low.
- R2: Register offsets: mode 0x00, reference 0x04, capture 0x08, count 0x0C, event 0x11. The event register holds the reference-match flag at bit 1 and the capture flag at bit 0. The capture flag is never set by hardware, and the capture register is a plain software read/write register. Other offsets read zero, and writes to them change nothing.
- R3: Mode bit 0 enables the timer. While it is 0 the count holds its value, including a value loaded by software.
- R4: A mode write that takes bit 0 from 1 to 0 clears the reference register. The mode register then holds exactly the written value.
- R5: Mode bits 15:8 hold P. The count advances once every P+1 source ticks. A write to mode or reference sets the count to 0 and clears the prescaler, so the first increment lands P+1 source ticks after the write edge.
- R6: Mode bits 2:1 select the source: 1 gives a tick on every clock, and 2 gives one tick per 16 clocks (counted from the restart). With 0 or 3 the count never advances.
- R7: On the clock edge where a tick makes the count equal the reference, event bit 1 is set. It stays set until software clears it.
- R8: A write to the event register clears each bit written as 1 and leaves the other bits unchanged.
- R9: `irq` is high exactly when mode bit 4 and event bit 1 are both 1. It follows any register write in the cycle after that write's edge.
- R10: A write to the count register loads the written value on that edge. The prescaler is not restarted.
- R11: With mode bit 3 set, a tick taken while the count equals the reference returns the count to 0. With bit 3 clear, the count passes the reference and keeps incrementing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: match flag AND interrupt enable |

## Verification
The bench samples the edge on which the match flag must first appear, for several prescale values and for both clock sources. A design that is off by one in the prescaler, or that does not clear the divider on restart, shows the flag one tick early or late. It also checks the count on the two ticks around a match, with restart on and with restart off. A design that wraps one tick early or late, or that restarts when it should not, gives a wrong count there. Further checks disable the timer with extra bits in the written word, toggle the interrupt enable while the flag is set, and clear only the unrelated event bit. These catch a design that fails to clear the reference, drops the written mode value, leaves `irq` stale, or clears every event bit on any write.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
   // register offsets (byte addresses)
   localparam int unsigned OFS_MODE = 'h00;
   localparam int unsigned OFS_REF  = 'h04;
   localparam int unsigned OFS_CAP  = 'h08;
   localparam int unsigned OFS_CNT  = 'h0C;
   localparam int unsigned OFS_EVT  = 'h11;

   // mode register fields
   localparam int unsigned BIT_EN      = 0;
   localparam int unsigned BIT_SRC_LO  = 1;
   localparam int unsigned BIT_RESTART = 3;
   localparam int unsigned BIT_IE      = 4;
   localparam int unsigned BIT_PRE_LO  = 8;

   // event register fields
   localparam int unsigned EVT_CAP = 0;
   localparam int unsigned EVT_REF = 1;
   localparam int unsigned EVT_W   = 2;

   typedef enum logic [1:0] {
      SRC_OFF0 = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_OFF3 = 2'd3
   } src_sel_e;
endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler
   import refcmp_pkg::*;
#(
   parameter int unsigned PRE_W   = 8,
   parameter int unsigned SRC_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [1:0]       src,
   input  logic [PRE_W-1:0] pre_val,
   output logic             tick
);
   logic             slow;
   logic             src_tick;
   logic [PRE_W-1:0] pre_q;

   generate
      if (SRC_DIV > 1) begin : g_div
         localparam int unsigned DW = $clog2(SRC_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            div_q <= '0;
            else if (clr || !run)  div_q <= '0;
            else                   div_q <= div_q + 1'b1;
         end
         assign slow = (div_q == DW'(SRC_DIV - 1));
      end else begin : g_nodiv
         assign slow = 1'b1;
      end
   endgenerate

   always_comb begin
      case (src_sel_e'(src))
         SRC_SYS:  src_tick = 1'b1;
         SRC_SLOW: src_tick = slow;
         default:  src_tick = 1'b0;
      endcase
   end

   assign tick = run && src_tick && (pre_q == pre_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pre_q <= '0;
      else if (clr || !run)     pre_q <= '0;
      else if (src_tick) begin
         if (pre_q == pre_val)  pre_q <= '0;
         else                   pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             restart_en,
   input  logic [CNT_W-1:0] ref_val,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = (restart_en && (cnt == ref_val)) ? '0 : cnt + 1'b1;
   assign hit     = tick && !ld && !clr && (cnt_nxt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (ld)    cnt <= ld_val;
      else if (clr)   cnt <= '0;
      else if (tick)  cnt <= cnt_nxt;
   end
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
   import refcmp_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned SRC_DIV = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              irq
);
   localparam int unsigned PRE_W = CNT_W - BIT_PRE_LO;

   generate
      if (CNT_W < BIT_PRE_LO + 1) begin : g_chk_w
         $error("refcmp_timer: CNT_W must leave room for the prescale field");
      end
      if (ADDR_W < 5) begin : g_chk_a
         $error("refcmp_timer: ADDR_W must reach the event offset");
      end
      if ((SRC_DIV & (SRC_DIV - 1)) != 0) begin : g_chk_d
         $error("refcmp_timer: SRC_DIV must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0] mode_q, ref_q, cap_q, cnt_q;
   logic [EVT_W-1:0] evt_q, evt_nxt;
   logic             wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt;
   logic             fall, restart, tick, hit;

   assign wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));
   assign wr_ref  = wr_en && (addr == ADDR_W'(OFS_REF));
   assign wr_cap  = wr_en && (addr == ADDR_W'(OFS_CAP));
   assign wr_cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
   assign wr_evt  = wr_en && (addr == ADDR_W'(OFS_EVT));
   assign fall    = wr_mode && mode_q[BIT_EN] && !wdata[BIT_EN];
   assign restart = wr_mode || wr_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
         cap_q  <= '0;
         evt_q  <= '0;
      end else begin
         if (wr_mode)    mode_q <= wdata;
         if (wr_ref)     ref_q  <= wdata;
         else if (fall)  ref_q  <= '0;
         if (wr_cap)     cap_q  <= wdata;
         evt_q <= evt_nxt;
      end
   end

   always_comb begin
      evt_nxt = evt_q;
      if (wr_evt) evt_nxt = evt_q & ~wdata[EVT_W-1:0];
      if (hit)    evt_nxt[EVT_REF] = 1'b1;
   end

   refcmp_prescaler #(.PRE_W(PRE_W), .SRC_DIV(SRC_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .run     (mode_q[BIT_EN]),
      .src     (mode_q[BIT_SRC_LO +: 2]),
      .pre_val (mode_q[CNT_W-1:BIT_PRE_LO]),
      .tick    (tick)
   );

   refcmp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (restart),
      .tick       (tick),
      .restart_en (mode_q[BIT_RESTART]),
      .ref_val    (ref_q),
      .ld         (wr_cnt),
      .ld_val     (wdata),
      .cnt        (cnt_q),
      .hit        (hit)
   );

   always_comb begin
      if      (addr == ADDR_W'(OFS_MODE)) rdata = mode_q;
      else if (addr == ADDR_W'(OFS_REF))  rdata = ref_q;
      else if (addr == ADDR_W'(OFS_CAP))  rdata = cap_q;
      else if (addr == ADDR_W'(OFS_CNT))  rdata = cnt_q;
      else if (addr == ADDR_W'(OFS_EVT))  rdata = {{(CNT_W-EVT_W){1'b0}}, evt_q};
      else                                rdata = '0;
   end

   assign irq = mode_q[BIT_IE] & evt_q[EVT_REF];
endmodule

// File: rtl/refcmp_timer_chk.sv
module refcmp_timer_chk
   import refcmp_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic [CNT_W-1:0]  mode_q,
   input logic [CNT_W-1:0]  ref_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [EVT_W-1:0]  evt_q
);
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(mode_q[BIT_EN]) && !$past(wr_en)) |-> $stable(cnt_q)); // R3

   AST_FALL_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(addr) == ADDR_W'(OFS_MODE) && $past(mode_q[BIT_EN]) && !$past(wdata[BIT_EN]))
      |-> (ref_q == '0 && mode_q == $past(wdata))); // R4

   AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt_q[EVT_REF]) && !($past(wr_en) && $past(addr) == ADDR_W'(OFS_EVT) && $past(wdata[EVT_REF])))
      |-> evt_q[EVT_REF]); // R7

   AST_CAP_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(evt_q[EVT_CAP]) |-> !evt_q[EVT_CAP]); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$stable(cnt_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0)); // R11
endmodule

bind refcmp_timer refcmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .mode_q (mode_q),
   .ref_q  (ref_q),
   .cnt_q  (cnt_q),
   .evt_q  (evt_q)
);

// File: tb/sim_refcmp_timer.sv
`timescale 1ns/100ps
module sim_refcmp_timer;
   localparam int unsigned CW = 16;
   localparam int unsigned AW = 5;
   localparam logic [AW-1:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                             A_CNT = 5'h0C, A_EVT = 5'h11, A_NONE = 5'h14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [CW-1:0] wdata = '0;
   logic [CW-1:0] rdata;
   logic          irq;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [CW-1:0] d;
      logic          i;
      string         tag;
   } exp_t;
   exp_t q[$];
   event smp_ev;

   always #2.5 clk = ~clk;

   refcmp_timer #(.CNT_W(CW), .ADDR_W(AW), .SRC_DIV(16)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // monitor: pops expected items and compares them with the ports
   initial begin
      forever begin : mon
         exp_t it;
         @(smp_ev);
         #1;
         it = q.pop_front();
         checks++;
         if (rdata !== it.d || irq !== it.i) begin
            bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     it.tag, rdata, irq, it.d, it.i);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expectation, triggers the monitor, uses one cycle
   task automatic rd(input logic [AW-1:0] a, input logic [CW-1:0] d,
                     input logic i, input string tag);
      exp_t it;
      addr = a;
      it.d = d; it.i = i; it.tag = tag;
      q.push_back(it);
      -> smp_ev;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // reset state
      rd(A_MODE, 16'h0000, 1'b0, "R1 mode");
      rd(A_REF,  16'h0000, 1'b0, "R1 ref");
      rd(A_CAP,  16'h0000, 1'b0, "R1 cap");
      rd(A_CNT,  16'h0000, 1'b0, "R1 cnt");
      rd(A_EVT,  16'h0000, 1'b0, "R1 evt");

      // disabled timer, map, unused offset
      wr(A_REF, 16'd5);
      idle(10);
      rd(A_CNT, 16'h0000, 1'b0, "R3 disabled holds");
      wr(A_CAP, 16'hBEEF);
      rd(A_CAP, 16'hBEEF, 1'b0, "R2 capture rw");
      wr(A_NONE, 16'hFFFF);
      rd(A_MODE, 16'h0000, 1'b0, "R2 stray write mode");
      rd(A_REF,  16'd5,    1'b0, "R2 stray write ref");
      rd(A_NONE, 16'h0000, 1'b0, "R2 unused reads zero");

      // run at system clock, P=0, no restart
      wr(A_MODE, 16'h0003);
      rd(A_CNT, 16'd0, 1'b0, "R5 count after restart");
      rd(A_CNT, 16'd1, 1'b0, "R6 one per clock");
      idle(2);
      rd(A_CNT, 16'd4, 1'b0, "R6 count 4");
      rd(A_EVT, 16'h0002, 1'b0, "R7 match flag, R9 no irq without enable");
      rd(A_CNT, 16'd6, 1'b0, "R11 passes ref without restart");

      // write-one-to-clear
      wr(A_EVT, 16'h0001);
      rd(A_EVT, 16'h0002, 1'b0, "R8 other bit kept");
      wr(A_EVT, 16'h0002);
      rd(A_EVT, 16'h0000, 1'b0, "R8 ref bit cleared");

      // interrupt
      wr(A_MODE, 16'h0013);
      idle(4);
      rd(A_EVT, 16'h0000, 1'b0, "R7 not yet matched");
      rd(A_EVT, 16'h0002, 1'b1, "R9 irq on match");
      wr(A_MODE, 16'h0003);
      rd(A_EVT, 16'h0002, 1'b0, "R9 irq off when disabled");
      wr(A_MODE, 16'h0013);
      rd(A_EVT, 16'h0002, 1'b1, "R9 irq back on enable");
      wr(A_EVT, 16'h0002);
      rd(A_EVT, 16'h0000, 1'b0, "R9 irq drops on clear");

      // disable clears reference
      wr(A_MODE, 16'h0000);
      rd(A_REF,  16'h0000, 1'b0, "R4 ref cleared");
      rd(A_MODE, 16'h0000, 1'b0, "R4 mode stored");
      wr(A_REF, 16'd7);
      wr(A_MODE, 16'h0011);
      wr(A_MODE, 16'h0A10);
      rd(A_MODE, 16'h0A10, 1'b0, "R4 written value kept");
      rd(A_REF,  16'h0000, 1'b0, "R4 ref cleared again");
      wr(A_CNT, 16'h0123);
      idle(5);
      rd(A_CNT, 16'h0123, 1'b0, "R3 R10 loaded value holds");

      // prescale P=2
      wr(A_REF, 16'd3);
      wr(A_MODE, 16'h0203);
      idle(8);
      rd(A_EVT, 16'h0000, 1'b0, "R5 before 9th clock");
      rd(A_EVT, 16'h0002, 1'b0, "R5 match at 9th clock");
      rd(A_CNT, 16'd3,    1'b0, "R5 count held between ticks");

      // divide-by-16 source, P=1
      wr(A_REF, 16'd2);
      wr(A_EVT, 16'h0003);
      wr(A_MODE, 16'h0105);
      idle(63);
      rd(A_EVT, 16'h0000, 1'b0, "R6 slow source before 64");
      rd(A_EVT, 16'h0002, 1'b0, "R6 slow source match at 64");

      // unsupported sources
      wr(A_MODE, 16'h0001);
      idle(20);
      rd(A_CNT, 16'd0, 1'b0, "R6 source 0 frozen");
      wr(A_MODE, 16'h0007);
      idle(20);
      rd(A_CNT, 16'd0, 1'b0, "R6 source 3 frozen");

      // restart on match
      wr(A_EVT, 16'h0003);
      wr(A_REF, 16'd3);
      wr(A_MODE, 16'h000B);
      idle(3);
      rd(A_CNT, 16'd3, 1'b0, "R11 reaches ref");
      rd(A_CNT, 16'd0, 1'b0, "R11 wraps to zero");
      rd(A_CNT, 16'd1, 1'b0, "R11 continues");
      rd(A_EVT, 16'h0002, 1'b0, "R7 flag from restart run");

      // counter load while running
      wr(A_CNT, 16'h0010);
      rd(A_CNT, 16'h0010, 1'b0, "R10 load");
      rd(A_CNT, 16'h0011, 1'b0, "R10 counts from loaded value");

      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule